// File: doc/BRIEF.md
# Chained Pair of 64-bit Event Counters

This block holds two 64-bit event counters, an even one and an odd one, of the kind found in a performance-monitoring unit. Each counter adds one on every cycle in which its event input is high and the counter is enabled. Every counted event increments all 64 bits. A single long-overflow control bit only moves the point at which a counter's overflow flag is raised. With the bit at 0, the flag is raised when the low 32 bits wrap. With the bit at 1, it is raised when the whole 64-bit value wraps.

When chaining is on, the odd counter no longer looks at its own event input. It instead counts every carry out of bit 31 of the even counter. Each counter can be loaded by a software write. Overflows accumulate in a two-bit sticky status register that is cleared by writing ones. An interrupt output is raised while any status bit is set and its enable bit is also set.

Top module: `evt_pair_ctr`

## Requirements
- R1: An increment happens when a counter's enable is high, its event is high, and no write targets it in that cycle. After such a cycle, the 64-bit counter value equals its old value plus one, including the carry into bits [63:32].
- R2: With `long_ovf` = 0, an increment that carries out of bits [31:0] sets that counter's status bit on the next cycle. Bits [63:32] still increment.
- R3: With `long_ovf` = 1, a carry out of bits [31:0] alone leaves the status bit unchanged. The bit is set only by an increment from 0xFFFFFFFF_FFFFFFFF, which wraps the counter to zero.
- R4: Status bit 0 (`ovs[0]`) belongs to the even counter and bit 1 (`ovs[1]`) to the odd counter. Each counter's overflow sets only its own bit.
- R5: With `chain_en` = 1, the odd counter ignores `evt[1]` and increments exactly once for each carry out of bits [31:0] of the even counter. Starting from even = 0x00000000_FFFFFFFF and odd = 0 with `long_ovf` = 0, one even event gives even = 0x00000001_00000000, odd = 1 and `ovs` = 0b01.
- R6: In chained mode with `long_ovf` = 0, suppose the even counter wraps its low half while the odd counter holds 0x00000000_FFFFFFFF. Then the odd counter becomes 0x00000001_00000000 and `ovs` reads 0b11.
- R7: Status bits are sticky. When `ovs_clr_we` = 1, each 1 in `ovs_clr_mask` clears the matching bit and each 0 leaves it unchanged. If a bit is set and cleared in the same cycle, it ends up set.
- R8: `irq` is high whenever `ovs & irq_en` is non-zero, and low otherwise.
- R9: A write (`wr_en[n]` = 1) loads all 64 bits of `wr_data` into counter n on the next cycle. An event on that counter in the same cycle is dropped and causes no increment or overflow.
- R10: A counter with `cnt_en[n]` = 0 neither increments nor sets its status bit. This also holds for the odd counter in chained mode, and when the even counter is disabled in chained mode the odd counter receives no carries.
- R11: During synchronous reset (`rst_n` = 0), both counters, `ovs` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| long_ovf | input | 1 | 0: flag on 32-bit wrap; 1: flag on 64-bit wrap |
| chain_en | input | 1 | Odd counter counts the even counter's 32-bit carries |
| cnt_en | input | 2 | Per-counter enable (bit 0 even, bit 1 odd) |
| evt | input | 2 | Per-counter event pulse |
| wr_en | input | 2 | Per-counter software load strobe |
| wr_data0 | input | 64 | Load value for the even counter |
| wr_data1 | input | 64 | Load value for the odd counter |
| ovs_clr_we | input | 1 | Strobe for a write-one-to-clear of the status register |
| ovs_clr_mask | input | 2 | Bits to clear when `ovs_clr_we` is high |
| irq_en | input | 2 | Per-bit interrupt enable |
| cnt0 | output | 64 | Even counter value |
| cnt1 | output | 64 | Odd counter value |
| ovs | output | 2 | Sticky overflow status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a double carry in chained mode: the even counter's low half wraps while the odd counter sits one count below its own wrap point, under either overflow setting. Counting up to these values would take billions of cycles. The stimulus therefore uses the software load ports to place both counters at 0x00000000_FFFFFFFF, 0xFFFFFFFF_FFFFFFFE and similar values, then issues single events. A randomized phase also draws load values from this set of near-boundary values while it toggles chaining, enables, writes and clears. This makes same-cycle collisions of load, event, set and clear happen many times.

// File: rtl/evt_pair_pkg.sv
// Package: shared widths and types for the chained event-counter pair.
// Assumes exactly two counters (even/odd) and a low-half width below the
// full counter width.
package evt_pair_pkg;
    localparam int unsigned CNT_W   = 64;
    localparam int unsigned LO_W    = 32;
    localparam int unsigned NUM_CTR = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [NUM_CTR-1:0] ctr_vec_t;
endpackage

// File: rtl/epc_counter.sv
// Module: one wide event counter with a software load port.
// What it does: loads ld_val when ld is high, otherwise adds one when inc is
// high, and reports whether the low half and the whole value are all ones.
// Assumes: the caller never raises inc together with ld (load has priority
// anyway).
module epc_counter #(
    parameter int unsigned W  = 64,
    parameter int unsigned LO = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         lo_ones,
    output logic         all_ones
);

    // Counter register: reset, load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= q + {{(W-1){1'b0}}, 1'b1};
        end
    end

    // Wrap-point detectors used by the routing logic.
    always_comb begin
        lo_ones  = &q[LO-1:0];
        all_ones = &q;
    end

    // R1
    inc_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> (q == $past(q) + {{(W-1){1'b0}}, 1'b1}));

    // R2
    upper_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && lo_ones && !all_ones) |=>
            (q[W-1:LO] == $past(q[W-1:LO]) + {{(W-LO-1){1'b0}}, 1'b1}) && (q[LO-1:0] == '0));

    // R9
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(ld_val)));

endmodule

// File: rtl/epc_route.sv
// Module: increment and overflow routing for the counter pair.
// What it does: decides which counter increments this cycle (own event, or the
// even counter's low-half carry when chained) and which status bits to set,
// according to the long-overflow selection.
// Assumes: lo_ones/all_ones come straight from the counter registers.
module epc_route (
    input  logic       chain_en,
    input  logic       long_ovf,
    input  logic [1:0] cnt_en,
    input  logic [1:0] evt,
    input  logic [1:0] wr_en,
    input  logic [1:0] lo_ones,
    input  logic [1:0] all_ones,
    output logic [1:0] inc,
    output logic [1:0] ovf_set
);

    logic inc_e, inc_o;
    logic lo_c_e, lo_c_o;
    logic full_c_e, full_c_o;

    // Even counter: own event only, and never in a load cycle.
    always_comb begin
        inc_e    = cnt_en[0] & evt[0] & ~wr_en[0];
        lo_c_e   = inc_e & lo_ones[0];
        full_c_e = inc_e & all_ones[0];
    end

    // Odd counter: own event, or the even low-half carry when chained.
    always_comb begin
        inc_o    = cnt_en[1] & ~wr_en[1] & (chain_en ? lo_c_e : evt[1]);
        lo_c_o   = inc_o & lo_ones[1];
        full_c_o = inc_o & all_ones[1];
    end

    // Output packing and overflow-point selection.
    always_comb begin
        inc     = {inc_o, inc_e};
        ovf_set = long_ovf ? {full_c_o, full_c_e} : {lo_c_o, lo_c_e};
    end

endmodule

// File: rtl/epc_ovf_status.sv
// Module: sticky overflow status with write-one-to-clear and interrupt.
// What it does: ORs newly seen overflows into a status register, clears bits
// written as one, lets a same-cycle set win, and raises irq for enabled bits.
// Assumes: set_vec is a single-cycle strobe per overflow.
module epc_ovf_status #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] ovs,
    output logic         irq
);

    logic [N-1:0] clr_eff;

    // Clear strobe qualified by the write enable.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Status register: clear first, then set so that a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovs <= '0;
        end else begin
            ovs <= (ovs & ~clr_eff) | set_vec;
        end
    end

    // Interrupt: any enabled status bit.
    always_comb irq = |(ovs & irq_en);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // R7
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovs[i] && !(clr_we && clr_mask[i])) |=> ovs[i]);
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> ovs[i]);
        // R7
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set_vec[i]) |=> !ovs[i]);
    end

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovs & irq_en) != '0) |-> irq);

endmodule

// File: rtl/evt_pair_ctr.sv
// Module: top of the chained event-counter pair.
// What it does: two 64-bit counters, optional chaining of the odd counter onto
// the even counter's 32-bit carry, selectable overflow point, sticky status
// and interrupt.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module evt_pair_ctr
    import evt_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        long_ovf,
    input  logic        chain_en,
    input  logic [1:0]  cnt_en,
    input  logic [1:0]  evt,
    input  logic [1:0]  wr_en,
    input  logic [63:0] wr_data0,
    input  logic [63:0] wr_data1,
    input  logic        ovs_clr_we,
    input  logic [1:0]  ovs_clr_mask,
    input  logic [1:0]  irq_en,
    output logic [63:0] cnt0,
    output logic [63:0] cnt1,
    output logic [1:0]  ovs,
    output logic        irq
);

    cnt_t     ld_val [NUM_CTR];
    cnt_t     q      [NUM_CTR];
    ctr_vec_t lo_ones, all_ones, inc, ovf_set;

    // Gather the per-counter load data into an indexed array.
    always_comb begin
        ld_val[0] = wr_data0;
        ld_val[1] = wr_data1;
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        epc_counter #(.W(CNT_W), .LO(LO_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld       (wr_en[i]),
            .ld_val   (ld_val[i]),
            .inc      (inc[i]),
            .q        (q[i]),
            .lo_ones  (lo_ones[i]),
            .all_ones (all_ones[i])
        );
    end

    epc_route u_route (
        .chain_en (chain_en),
        .long_ovf (long_ovf),
        .cnt_en   (cnt_en),
        .evt      (evt),
        .wr_en    (wr_en),
        .lo_ones  (lo_ones),
        .all_ones (all_ones),
        .inc      (inc),
        .ovf_set  (ovf_set)
    );

    epc_ovf_status #(.N(NUM_CTR)) u_ovs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (ovf_set),
        .clr_we   (ovs_clr_we),
        .clr_mask (ovs_clr_mask),
        .irq_en   (irq_en),
        .ovs      (ovs),
        .irq      (irq)
    );

    // Drive the counter outputs.
    always_comb begin
        cnt0 = q[0];
        cnt1 = q[1];
    end

    // R5
    chain_ignores_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && !wr_en[1] &&
         !(cnt_en[0] && evt[0] && !wr_en[0] && (&cnt0[LO_W-1:0]))) |=> $stable(cnt1));

    // R10
    even_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en[0] && !wr_en[0]) |=> ($stable(cnt0) && !$rose(ovs[0])));

    // R10
    odd_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en[1] && !wr_en[1]) |=> ($stable(cnt1) && !$rose(ovs[1])));

    // R3
    long_no_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (long_ovf && !(&cnt0)) |=> !$rose(ovs[0]));

endmodule

// File: tb/sim_evt_pair_ctr.sv
module sim_evt_pair_ctr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_ovf = 1'b0, chain_en = 1'b0;
    logic [1:0]  cnt_en = '0, evt = '0, wr_en = '0, ovs_clr_mask = '0, irq_en = '0;
    logic        ovs_clr_we = 1'b0;
    logic [63:0] wr_data0 = '0, wr_data1 = '0;
    logic [63:0] cnt0, cnt1;
    logic [1:0]  ovs;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m0 = '0, m1 = '0;
    logic [1:0]  movs = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_pair_ctr u0 (
        .clk(clk), .rst_n(rst_n), .long_ovf(long_ovf), .chain_en(chain_en),
        .cnt_en(cnt_en), .evt(evt), .wr_en(wr_en), .wr_data0(wr_data0),
        .wr_data1(wr_data1), .ovs_clr_we(ovs_clr_we), .ovs_clr_mask(ovs_clr_mask),
        .irq_en(irq_en), .cnt0(cnt0), .cnt1(cnt1), .ovs(ovs), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "cnt0", cnt0, m0);
        check(tag, "cnt1", cnt1, m1);
        check(tag, "ovs", {62'd0, ovs}, {62'd0, movs});
        check(tag, "irq", {63'd0, irq}, {63'd0, |(movs & irq_en)});
    endtask

    // One clock: inputs are already driven; update the model at the edge,
    // compare at the following falling edge.
    task automatic cyc(input string tag);
        logic e_inc, o_inc, lo_e, hi_e, lo_o, hi_o;
        logic [1:0] setv, clr;
        @(posedge clk);
        if (!rst_n) begin
            m0 = '0; m1 = '0; movs = '0;
        end else begin
            e_inc = cnt_en[0] && evt[0] && !wr_en[0];
            lo_e  = e_inc && (m0[31:0] == 32'hFFFF_FFFF);
            hi_e  = e_inc && (m0 == '1);
            o_inc = cnt_en[1] && !wr_en[1] && (chain_en ? lo_e : evt[1]);
            lo_o  = o_inc && (m1[31:0] == 32'hFFFF_FFFF);
            hi_o  = o_inc && (m1 == '1);
            setv  = long_ovf ? {hi_o, hi_e} : {lo_o, lo_e};
            clr   = ovs_clr_we ? ovs_clr_mask : 2'b00;
            if (wr_en[0]) m0 = wr_data0; else if (e_inc) m0 = m0 + 64'd1;
            if (wr_en[1]) m1 = wr_data1; else if (o_inc) m1 = m1 + 64'd1;
            movs = (movs & ~clr) | setv;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        evt = '0; wr_en = '0; ovs_clr_we = 1'b0; ovs_clr_mask = '0;
    endtask

    task automatic load(input logic [63:0] a, input logic [63:0] b, input string tag);
        idle_inputs();
        wr_en = 2'b11; wr_data0 = a; wr_data1 = b;
        cyc(tag);
        idle_inputs();
    endtask

    task automatic clear_all(input string tag);
        idle_inputs();
        ovs_clr_we = 1'b1; ovs_clr_mask = 2'b11;
        cyc(tag);
        idle_inputs();
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 5))
            0: return 64'h0000_0000_FFFF_FFFF;
            1: return 64'h0000_0000_FFFF_FFFE;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'hFFFF_FFFF_FFFF_FFFE;
            4: return 64'h0000_0001_FFFF_FFFF;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        evt = 2'b11; cnt_en = 2'b11;
        repeat (2) cyc("R11");
        idle_inputs(); cnt_en = '0;
        cyc("R11");
        rst_n = 1'b1;
        cyc("R11");

        // R1: plain counting on both counters, then carry into upper half
        cnt_en = 2'b11; irq_en = 2'b11;
        evt = 2'b11; repeat (3) cyc("R1");
        evt = 2'b01; repeat (2) cyc("R1");
        idle_inputs(); cyc("R1");
        load(64'h0000_0000_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, "R1");
        evt = 2'b11; cyc("R1");
        idle_inputs();
        clear_all("R7");

        // R9: load with a same-cycle event drops the event
        evt = 2'b11; wr_en = 2'b01; wr_data0 = 64'hDEAD_BEEF_0000_0010;
        cyc("R9");
        wr_en = 2'b10; wr_data1 = 64'h0000_0000_FFFF_FFFF; cyc("R9");
        idle_inputs(); cyc("R9");

        // R2: short overflow sets the flag and upper half increments
        long_ovf = 1'b0;
        load(64'h0000_0007_FFFF_FFFE, 64'h0, "R2");
        evt = 2'b01; repeat (3) cyc("R2");
        idle_inputs();

        // R7: clear with zeros, partial clear, set and clear together
        ovs_clr_we = 1'b1; ovs_clr_mask = 2'b00; cyc("R7");
        ovs_clr_mask = 2'b10; cyc("R7");
        ovs_clr_mask = 2'b01; cyc("R7");
        idle_inputs();
        load(64'h0000_0000_FFFF_FFFF, 64'h0, "R7");
        evt = 2'b01; ovs_clr_we = 1'b1; ovs_clr_mask = 2'b01; cyc("R7");
        idle_inputs(); cyc("R7");
        clear_all("R7");

        // R3: long overflow ignores 32-bit wrap, flags 64-bit wrap
        long_ovf = 1'b1;
        load(64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, "R3");
        evt = 2'b11; repeat (3) cyc("R3");
        idle_inputs();
        load(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R3");
        evt = 2'b01; cyc("R3");
        idle_inputs(); cyc("R3");
        clear_all("R7");

        // R4: only the odd counter overflows
        long_ovf = 1'b0;
        load(64'h0, 64'h0000_0000_FFFF_FFFF, "R4");
        evt = 2'b10; cyc("R4");
        idle_inputs(); cyc("R4");
        clear_all("R4");

        // R5: chained, odd ignores its own event, counts even carries
        chain_en = 1'b1;
        load(64'h0000_0000_FFFF_FFFF, 64'h0, "R5");
        evt = 2'b11; cyc("R5");
        evt = 2'b10; repeat (3) cyc("R5");
        evt = 2'b11; repeat (2) cyc("R5");
        idle_inputs();
        clear_all("R5");

        // R6: double carry with odd at its low-half wrap
        load(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R6");
        evt = 2'b01; cyc("R6");
        idle_inputs(); cyc("R6");
        // same with long overflow selected: no flags
        clear_all("R6");
        long_ovf = 1'b1;
        load(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R6");
        evt = 2'b01; cyc("R6");
        idle_inputs();
        long_ovf = 1'b0;
        clear_all("R6");

        // R8: interrupt follows enabled status bits
        load(64'h0000_0000_FFFF_FFFF, 64'h0, "R8");
        irq_en = 2'b10; evt = 2'b01; cyc("R8");
        idle_inputs(); cyc("R8");
        irq_en = 2'b01; cyc("R8");
        irq_en = 2'b00; cyc("R8");
        irq_en = 2'b11;
        clear_all("R8");

        // R10: disabled counters in chained and unchained modes
        load(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R10");
        cnt_en = 2'b10; evt = 2'b11; repeat (2) cyc("R10");
        cnt_en = 2'b01; repeat (2) cyc("R10");
        chain_en = 1'b0; cnt_en = 2'b00; repeat (2) cyc("R10");
        idle_inputs(); cnt_en = 2'b11;
        clear_all("R10");

        // Mixed random phase across all requirements (R1..R10 interplay)
        for (int k = 0; k < 3000; k++) begin
            long_ovf     = ($urandom_range(0, 3) == 0);
            chain_en     = $urandom_range(0, 1);
            cnt_en       = ($urandom_range(0, 4) == 0) ? 2'($urandom()) : 2'b11;
            evt          = 2'($urandom());
            wr_en        = ($urandom_range(0, 5) == 0) ? 2'($urandom()) : 2'b00;
            wr_data0     = pick();
            wr_data1     = pick();
            ovs_clr_we   = ($urandom_range(0, 7) == 0);
            ovs_clr_mask = 2'($urandom());
            irq_en       = 2'($urandom());
            cyc("R1_R10_mix");
        end
        idle_inputs();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule